// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Manual Set

This block keeps the time of day as six packed BCD digits, two each for seconds, minutes and hours, in 24-hour form from 00:00:00 to 23:59:59. A one-cycle tick in the system clock domain, once per second, moves the seconds field forward. Each field carries into the next higher one when it rolls over. Everything runs on a single system clock. The tick and the derived advance pulse act only as enables.

To set the time, the user raises a correction-mode line and the select line of one field, then presses an advance input. Each rising edge of that input steps the selected field by one, as if an extra tick had reached that field alone. A field stepped this way wraps within its own range and does not carry into the next field. The advance input is edge-detected inside the block, so a press that is held counts once.

Top module: `tod_bcd_clock`

## Requirements
- R1: A synchronous active-high reset clears all six digits to zero (time 00:00:00).
- R2: The seconds-units digit increments by one on the clock edge at which the tick is sampled high. The digits are unchanged in a cycle with neither a tick nor an advance pulse for that field.
- R3: Seconds units count 0 to 9 and carry into the seconds tens. Seconds tens count 0 to 5. A tick at seconds 59 gives seconds 00 and increments the minutes field on the same edge.
- R4: Minutes behave like seconds. When a tick-driven carry reaches minutes 59, minutes go to 00 and the hours field increments on the same edge.
- R5: Hours run 00 to 23. The units digit carries into the tens at 9 (09 to 10, 19 to 20). Stepping from 23 gives 00, so 23:59:59 plus one tick is 00:00:00.
- R6: With correction mode high, each rising edge of the advance input steps every field whose select line is high by one. The step lands on the clock edge at which the advance input is first sampled high. Holding the input high for more cycles adds nothing.
- R7: An advance edge has no effect on a field when correction mode is low or that field's select line is low.
- R8: A field stepped by an advance edge wraps within its own range without carrying. Minutes 59 step to 00 and leave the hours unchanged. Hours 23 step to 00.
- R9: Every digit output is 4-bit BCD (value 0 to 9). Bit 3 of each tens digit is always 0.
- R10: A tick and a seconds advance pulse on the same edge step the seconds field once, not twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| corr_mode | input | 1 | Correction (set) mode enable |
| pick_sec | input | 1 | Selects the seconds field for advancing |
| pick_min | input | 1 | Selects the minutes field for advancing |
| pick_hr | input | 1 | Selects the hours field for advancing |
| adv_in | input | 1 | Advance button level, synchronous; its rising edge steps the selected field |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |

## Verification
The hardest state to reach is the full cascade from 23:59:59. Reaching it by ticks alone takes 86,399 ticks, and the 09:59:59 units-to-tens carry of the hours needs a similar run. The bench reaches both by first stepping each field to its target with correction-mode advance presses, which do not carry. It then applies a single tick and checks the whole rollover on one edge. The same preset path gives the no-carry checks at 59 minutes and 23 hours, and a tick and an advance edge are placed on one edge to show the seconds field steps only once.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] ONES_TOP = DIGIT_W'(9);

  // true when a units digit must roll to zero and bump its tens digit
  function automatic logic ones_rolls(input logic [DIGIT_W-1:0] ones);
    return ones == ONES_TOP;
  endfunction

  // next units digit value when the field steps without wrapping whole
  function automatic logic [DIGIT_W-1:0] ones_next(input logic [DIGIT_W-1:0] ones);
    return ones_rolls(ones) ? '0 : ones + DIGIT_W'(1);
  endfunction

  // true when a two-digit field sits on its last value
  function automatic logic field_at_last(input logic [DIGIT_W-1:0] tens,
                                         input logic [DIGIT_W-1:0] ones,
                                         input int tens_last,
                                         input int ones_last);
    return (tens == DIGIT_W'(tens_last)) && (ones == DIGIT_W'(ones_last));
  endfunction
endpackage

// File: rtl/tod_rise.sv
module tod_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign pulse = lvl & ~lvl_q;
endmodule

// File: rtl/tod_field.sv
module tod_field
  import tod_pkg::*;
#(
  parameter int TENS_BITS = 3,
  parameter int TENS_LAST = 5,
  parameter int ONES_LAST = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               set_en,
  output logic [DIGIT_W-1:0] ones,
  output logic [DIGIT_W-1:0] tens,
  output logic               carry_out
);
  logic [DIGIT_W-1:0]   ones_q;
  logic [TENS_BITS-1:0] tens_q;
  logic                 step;
  logic                 at_last;

  assign tens    = DIGIT_W'(tens_q);
  assign ones    = ones_q;
  assign step    = cnt_en | set_en;
  assign at_last = field_at_last(tens, ones_q, TENS_LAST, ONES_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q <= '0;
      tens_q <= '0;
    end else if (step) begin
      if (at_last) begin
        ones_q <= '0;
        tens_q <= '0;
      end else begin
        ones_q <= ones_next(ones_q);
        if (ones_rolls(ones_q)) tens_q <= tens_q + TENS_BITS'(1);
      end
    end
  end

  // only a counting step carries; a manual step wraps in place
  assign carry_out = cnt_en & at_last;
endmodule

// File: rtl/tod_bcd_clock.sv
module tod_bcd_clock
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1hz,
  input  logic       corr_mode,
  input  logic       pick_sec,
  input  logic       pick_min,
  input  logic       pick_hr,
  input  logic       adv_in,
  output logic [3:0] sec_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [3:0] min_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] hr_tens
);
  logic adv_pulse;
  logic sec_set, min_set, hr_set;
  logic sec_carry, min_carry, hr_carry;

  tod_rise u_rise (
    .clk(clk), .rst(rst), .lvl(adv_in), .pulse(adv_pulse)
  );

  assign sec_set = corr_mode & pick_sec & adv_pulse;
  assign min_set = corr_mode & pick_min & adv_pulse;
  assign hr_set  = corr_mode & pick_hr  & adv_pulse;

  tod_field #(.TENS_BITS(3), .TENS_LAST(5), .ONES_LAST(9)) u_sec (
    .clk(clk), .rst(rst), .cnt_en(tick_1hz), .set_en(sec_set),
    .ones(sec_ones), .tens(sec_tens), .carry_out(sec_carry)
  );

  tod_field #(.TENS_BITS(3), .TENS_LAST(5), .ONES_LAST(9)) u_min (
    .clk(clk), .rst(rst), .cnt_en(sec_carry), .set_en(min_set),
    .ones(min_ones), .tens(min_tens), .carry_out(min_carry)
  );

  tod_field #(.TENS_BITS(2), .TENS_LAST(2), .ONES_LAST(3)) u_hr (
    .clk(clk), .rst(rst), .cnt_en(min_carry), .set_en(hr_set),
    .ones(hr_ones), .tens(hr_tens), .carry_out(hr_carry)
  );
endmodule

// File: rtl/tod_bcd_clock_chk.sv
module tod_bcd_clock_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic       corr_mode,
  input logic       pick_sec,
  input logic       pick_min,
  input logic       pick_hr,
  input logic       adv_pulse,
  input logic       sec_carry,
  input logic       min_carry,
  input logic [3:0] sec_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] min_ones,
  input logic [3:0] min_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] hr_tens
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sec_ones == 0 && sec_tens == 0 && min_ones == 0 &&
             min_tens == 0 && hr_ones == 0 && hr_tens == 0));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_1hz && !(corr_mode && pick_sec && adv_pulse)) |=>
      ($stable(sec_ones) && $stable(sec_tens)));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    sec_carry |=> (sec_ones == 0 && sec_tens == 0));

  // R4
  min_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    min_carry |=> (min_ones == 0 && min_tens == 0));

  // R5
  hr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_tens < 4'd2) || (hr_tens == 4'd2 && hr_ones <= 4'd3));

  // R6
  adv_single_chk: assert property (@(posedge clk) disable iff (rst)
    adv_pulse |=> !adv_pulse);

  // R8
  min_set_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_pulse && corr_mode && pick_min && !pick_hr && !tick_1hz) |=>
      ($stable(hr_ones) && $stable(hr_tens)));

  // R9
  bcd_form_chk: assert property (@(posedge clk) disable iff (rst)
    sec_ones <= 4'd9 && min_ones <= 4'd9 && hr_ones <= 4'd9 &&
    !sec_tens[3] && !min_tens[3] && !hr_tens[3]);
endmodule

bind tod_bcd_clock tod_bcd_clock_chk u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .corr_mode(corr_mode),
  .pick_sec(pick_sec), .pick_min(pick_min), .pick_hr(pick_hr),
  .adv_pulse(adv_pulse), .sec_carry(sec_carry), .min_carry(min_carry),
  .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
  .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens)
);

// File: tb/test_tod_bcd_clock.sv
module test_tod_bcd_clock;
  logic clk = 1'b0;
  logic rst, tick_1hz, corr_mode, pick_sec, pick_min, pick_hr, adv_in;
  logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;

  int total = 0;
  int bad   = 0;
  int eh, em, es;
  bit finished = 0;

  always #5 clk = ~clk;

  tod_bcd_clock i_tod_bcd_clock (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .corr_mode(corr_mode),
    .pick_sec(pick_sec), .pick_min(pick_min), .pick_hr(pick_hr),
    .adv_in(adv_in), .sec_ones(sec_ones), .sec_tens(sec_tens),
    .min_ones(min_ones), .min_tens(min_tens), .hr_ones(hr_ones),
    .hr_tens(hr_tens)
  );

  task automatic check_time(input string req);
    int ah, am, as_;
    ah  = hr_tens * 10 + hr_ones;
    am  = min_tens * 10 + min_ones;
    as_ = sec_tens * 10 + sec_ones;
    total++;
    if (ah != eh || am != em || as_ != es || hr_ones > 9 || min_ones > 9 || sec_ones > 9) begin
      bad++;
      $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d expected %02d:%02d:%02d", req,
               hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones, eh, em, es);
    end
  endtask

  task automatic check_bcd(input string req);
    total++;
    if (sec_tens[3] || min_tens[3] || hr_tens[3] ||
        sec_ones > 9 || min_ones > 9 || hr_ones > 9) begin
      bad++;
      $display("FAIL %s: tens top bits %b%b%b expected 000", req,
               hr_tens[3], min_tens[3], sec_tens[3]);
    end
  endtask

  // model of one counting tick
  function automatic void model_tick();
    es++;
    if (es == 60) begin
      es = 0; em++;
      if (em == 60) begin
        em = 0; eh = (eh + 1) % 24;
      end
    end
  endfunction

  task automatic do_tick();
    @(negedge clk) tick_1hz = 1'b1;
    @(negedge clk) tick_1hz = 1'b0;
    model_tick();
  endtask

  // field: 0 sec, 1 min, 2 hr; held for hold cycles
  task automatic press(input int field, input bit corr, input int hold);
    @(negedge clk);
    corr_mode = corr;
    pick_sec  = (field == 0);
    pick_min  = (field == 1);
    pick_hr   = (field == 2);
    adv_in    = 1'b1;
    repeat (hold) @(negedge clk);
    adv_in = 1'b0;
    @(negedge clk);
    corr_mode = 1'b0; pick_sec = 1'b0; pick_min = 1'b0; pick_hr = 1'b0;
    if (corr) begin
      case (field)
        0: es = (es + 1) % 60;
        1: em = (em + 1) % 60;
        default: eh = (eh + 1) % 24;
      endcase
    end
  endtask

  task automatic set_field(input int field, input int target);
    int cur, modv, n;
    cur  = (field == 0) ? es : (field == 1) ? em : eh;
    modv = (field == 2) ? 24 : 60;
    n = (target - cur + modv) % modv;
    for (int i = 0; i < n; i++) press(field, 1'b1, 1);
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    eh = 0; em = 0; es = 0;
    check_time("R1 reset");
    check_bcd("R9 reset");
  endtask

  task automatic t_tick_count();
    for (int i = 0; i < 9; i++) do_tick();
    check_time("R2 ticks to 9");
    do_tick();
    check_time("R3 units carry to tens");
    repeat (5) @(negedge clk);
    check_time("R2 idle hold");
    for (int i = 0; i < 50; i++) do_tick();
    check_time("R3 seconds wrap to minute");
  endtask

  task automatic t_manual();
    press(0, 1'b1, 4);
    check_time("R6 held press counts once");
    press(1, 1'b1, 1);
    check_time("R6 minute advance");
    press(1, 1'b0, 1);
    check_time("R7 no corr mode");
    @(negedge clk) corr_mode = 1'b1; adv_in = 1'b1;
    @(negedge clk) adv_in = 1'b0;
    @(negedge clk) corr_mode = 1'b0;
    check_time("R7 no select");
  endtask

  task automatic t_no_carry();
    set_field(1, 59);
    check_time("R6 minutes preset 59");
    press(1, 1'b1, 1);
    check_time("R8 minutes 59 wrap no hour carry");
    set_field(2, 23);
    press(2, 1'b1, 1);
    check_time("R8 hours 23 wrap to 00");
  endtask

  task automatic t_cascade();
    set_field(2, 9); set_field(1, 59); set_field(0, 59);
    check_time("R6 preset 09:59:59");
    do_tick();
    check_time("R5 hours units carry 09 to 10");
    set_field(2, 23); set_field(1, 59); set_field(0, 59);
    do_tick();
    check_time("R4 R5 full rollover to 00:00:00");
    check_bcd("R9 after rollover");
  endtask

  task automatic t_same_edge();
    set_field(0, 20);
    @(negedge clk);
    tick_1hz = 1'b1; corr_mode = 1'b1; pick_sec = 1'b1; adv_in = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0; adv_in = 1'b0; corr_mode = 1'b0; pick_sec = 1'b0;
    model_tick();
    check_time("R10 tick plus advance steps once");
  endtask

  initial begin
    rst = 1'b1; tick_1hz = 1'b0; corr_mode = 1'b0;
    pick_sec = 1'b0; pick_min = 1'b0; pick_hr = 1'b0; adv_in = 1'b0;
    t_reset();
    t_tick_count();
    t_manual();
    t_no_carry();
    t_cascade();
    t_same_edge();
    t_reset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule